// File: doc/BRIEF.md
# Port-Group Forwarding Mask Resolver

This block decides which egress ports receive one Layer-2 frame. It holds one table of port-group masks. Each mask has one bit per physical port plus one bit for the CPU port, which sits just above the last physical port. For every frame the resolver reads three entries from this table and ANDs them together. The result is the frame's egress set.

The first entry comes from the destination region at indices 0 to 63. On a MAC-table hit the index is the destination index supplied with the request. On a miss it is a programmable flood index, picked by the frame kind. The second entry comes from the aggregation region at indices 64 to 79, indexed by a 4-bit link aggregation code. It narrows a link aggregation group down to one member per flow. The third entry is at index 80 plus the ingress port number. It says which ports that ingress port may forward to.

By convention, software fills the table as follows:
- Destination entries below the physical port count hold a single bit for their own port.
- Indices 59 to 63 are kept for the CPU whitelist, unknown unicast, broadcast and non-IP multicast, IPv4 multicast and IPv6 multicast.
- The indices in between are free multicast groups.

The table has a single read port, so one lookup spends three cycles reading. A busy flag tells the requester and the configuration writer to wait.

Top module: `pgm_resolver`

## Requirements
- R1: After reset `busy` and `res_valid` are low, every table entry is zero (so any lookup yields an all-zero mask), and the flood indices are unicast = 60, multicast = 61, broadcast = 61.
- R2: When `req_hit` is 1, the destination entry read is the one at index `req_dest_idx` (0 to 63).
- R3: When `req_hit` is 0, the destination index is taken from a flood index selected by `req_kind`: 0 selects unicast, 1 selects multicast, and 2 or 3 select broadcast.
- R4: The aggregation entry read is at index 64 + `req_aggr`.
- R5: The source entry read is at index 80 + `req_src`. `res_mask` is the bitwise AND of the destination, aggregation and source entries.
- R6: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is then 1 for the next three cycles. `res_valid` is 1 for exactly one cycle, starting at the third edge after acceptance. `req_valid` has no effect while `busy` is 1.
- R7: A table write (`cfg_tbl_we`, `cfg_addr`, `cfg_wdata`) takes effect at an edge where `busy` is 0. While `busy` is 1 the write has no effect, and the writer holds it until `busy` falls. The result of every lookup therefore reflects one table state.
- R8: If `req_src` is not below the physical port count, the result mask is all zero and `res_err` is 1. Otherwise `res_err` is 0.
- R9: A flood index write (`cfg_flood_we`) updates the index selected by `cfg_flood_sel` (0 unicast, 1 multicast, 2 broadcast; 3 has no effect) at the next edge, at any time. A lookup uses the flood index as it stood at its acceptance edge.
- R10: Mask bit `NUM_PORTS` is the CPU port and passes through the AND like any other port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_hit | input | 1 | Destination was found in the MAC table |
| req_dest_idx | input | 6 | Destination index for a hit |
| req_kind | input | 2 | Frame kind for a miss (0 uc, 1 mc, 2/3 bc) |
| req_aggr | input | 4 | Link aggregation code |
| req_src | input | PORT_W | Ingress port number |
| busy | output | 1 | Lookup in progress |
| res_valid | output | 1 | Result strobe |
| res_mask | output | NUM_PORTS+1 | Egress port mask, CPU at the top bit |
| res_err | output | 1 | Ingress port out of range |
| cfg_tbl_we | input | 1 | Table write enable |
| cfg_addr | input | 7 | Table write index |
| cfg_wdata | input | NUM_PORTS+1 | Table write mask |
| cfg_flood_we | input | 1 | Flood index write enable |
| cfg_flood_sel | input | 2 | Flood index to write |
| cfg_flood_idx | input | 6 | New flood index value |

## Verification
- **Timing of results:** a result is due at the third rising edge after its acceptance edge. `busy` covers the three edges in between.
- **Timing of writes:** a table write is due at the first edge where `busy` is low. A flood write is due at the very next edge.
- **Reference model:** the bench model updates on the same edges, using inputs that were driven half a period earlier. It keeps a phase count for the lookup in flight and resolves the three reads when that count reaches its last step.
- **Sampling:** `busy`, `res_valid`, `res_mask` and `res_err` are compared at every falling edge, so each output is sampled half a cycle after the edge that produced it.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int IDX_W      = 7;
  localparam int DST_W      = 6;
  localparam int AGGR_W     = 4;
  localparam int AGGR_BASE  = 64;
  localparam int SRC_BASE   = 80;
  localparam int FLOOD_UC_RST = 60;
  localparam int FLOOD_MC_RST = 61;
  localparam int FLOOD_BC_RST = 61;

  typedef enum logic [1:0] {
    KIND_UC  = 2'd0,
    KIND_MC  = 2'd1,
    KIND_BC  = 2'd2,
    KIND_BC2 = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DST  = 2'd1,
    PH_AGGR = 2'd2,
    PH_SRC  = 2'd3
  } lookup_phase_e;
endpackage

// File: rtl/pgm_index_gen.sv
module pgm_index_gen
  import pgm_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flood_we_i,
  input  logic [1:0]        flood_sel_i,
  input  logic [DST_W-1:0]  flood_idx_i,
  input  logic              hit_i,
  input  logic [DST_W-1:0]  dest_idx_i,
  input  logic [1:0]        kind_i,
  input  logic [AGGR_W-1:0] aggr_i,
  input  logic [PORT_W-1:0] src_i,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [IDX_W-1:0]  aggr_idx_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic              src_err_o
);
  logic [DST_W-1:0] fl_uc_q, fl_mc_q, fl_bc_q;
  logic [DST_W-1:0] fl_uc_d, fl_mc_d, fl_bc_d;
  logic [DST_W-1:0] flood_pick;

  // Flood index next state (R9)
  always_comb begin
    fl_uc_d = fl_uc_q;
    fl_mc_d = fl_mc_q;
    fl_bc_d = fl_bc_q;
    if (flood_we_i) begin
      case (flood_sel_i)
        2'd0:    fl_uc_d = flood_idx_i;
        2'd1:    fl_mc_d = flood_idx_i;
        2'd2:    fl_bc_d = flood_idx_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_uc_q <= DST_W'(FLOOD_UC_RST);
      fl_mc_q <= DST_W'(FLOOD_MC_RST);
      fl_bc_q <= DST_W'(FLOOD_BC_RST);
    end else if (flood_we_i) begin
      fl_uc_q <= fl_uc_d;
      fl_mc_q <= fl_mc_d;
      fl_bc_q <= fl_bc_d;
    end
  end

  // Miss path: kind picks the flood index (R3)
  always_comb begin
    case (frame_kind_e'(kind_i))
      KIND_UC: flood_pick = fl_uc_q;
      KIND_MC: flood_pick = fl_mc_q;
      default: flood_pick = fl_bc_q;
    endcase
  end

  always_comb begin
    src_err_o  = (int'(src_i) >= NUM_PORTS);
    dst_idx_o  = {1'b0, (hit_i ? dest_idx_i : flood_pick)};
    aggr_idx_o = IDX_W'(AGGR_BASE) + IDX_W'(aggr_i);
    src_idx_o  = src_err_o ? IDX_W'(SRC_BASE) : IDX_W'(SRC_BASE) + IDX_W'(src_i);
  end

  assert_flood_sel3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flood_we_i && flood_sel_i == 2'd3) |=>
      ($stable(fl_uc_q) && $stable(fl_mc_q) && $stable(fl_bc_q)));
endmodule

// File: rtl/pgm_table.sv
module pgm_table
  import pgm_pkg::*;
#(
  parameter int DEPTH  = 88,
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [MASK_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  input  logic              lookup_active_i,
  output logic [MASK_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][MASK_W-1:0] mem_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en_i && (int'(wr_addr_i) == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[e] <= '0;
      else if (ent_we) mem_q[e] <= wr_data_i;
    end
  end

  // Single read port
  always_comb begin
    rd_data_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (int'(rd_addr_i) == e) rd_data_o = mem_q[e];
    end
  end

  // Table is frozen while a lookup is reading it (R7)
  assert_table_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_active_i |=> $stable(mem_q));
endmodule

// File: rtl/pgm_lookup_seq.sv
module pgm_lookup_seq
  import pgm_pkg::*;
#(
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [IDX_W-1:0]  aggr_idx_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic              src_err_i,
  input  logic [MASK_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]  rd_addr_o,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [MASK_W-1:0] res_mask_o,
  output logic              res_err_o
);
  lookup_phase_e     phase_q, phase_d;
  logic [IDX_W-1:0]  dst_q, aggr_q, src_q;
  logic              err_q;
  logic [MASK_W-1:0] acc_q, acc_d;
  logic              valid_q, valid_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              rerr_q, rerr_d;
  logic              accept, acc_en, res_en;

  assign accept = req_valid_i && (phase_q == PH_IDLE);
  assign acc_en = (phase_q == PH_DST) || (phase_q == PH_AGGR);
  assign res_en = (phase_q == PH_SRC);

  always_comb begin
    case (phase_q)
      PH_AGGR: rd_addr_o = aggr_q;
      PH_SRC:  rd_addr_o = src_q;
      default: rd_addr_o = dst_q;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    acc_d   = acc_q;
    mask_d  = mask_q;
    rerr_d  = rerr_q;
    valid_d = 1'b0;
    case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_DST;
      PH_DST: begin
        acc_d   = rd_data_i;
        phase_d = PH_AGGR;
      end
      PH_AGGR: begin
        acc_d   = acc_q & rd_data_i;
        phase_d = PH_SRC;
      end
      PH_SRC: begin
        mask_d  = err_q ? '0 : (acc_q & rd_data_i);
        rerr_d  = err_q;
        valid_d = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      valid_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      aggr_q <= '0;
      src_q  <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      dst_q  <= dst_idx_i;
      aggr_q <= aggr_idx_i;
      src_q  <= src_idx_i;
      err_q  <= src_err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rerr_q <= 1'b0;
    end else if (res_en) begin
      mask_q <= mask_d;
      rerr_q <= rerr_d;
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign res_valid_o = valid_q;
  assign res_mask_o  = mask_q;
  assign res_err_o   = rerr_q;

  assert_result_after_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(phase_q == PH_SRC));
  assert_no_valid_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !valid_q);
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DST) |=> (phase_q == PH_AGGR));
  assert_err_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rerr_q) |-> (mask_q == '0));
endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
  import pgm_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_hit,
  input  logic [5:0]           req_dest_idx,
  input  logic [1:0]           req_kind,
  input  logic [3:0]           req_aggr,
  input  logic [PORT_W-1:0]    req_src,
  output logic                 busy,
  output logic                 res_valid,
  output logic [NUM_PORTS:0]   res_mask,
  output logic                 res_err,
  input  logic                 cfg_tbl_we,
  input  logic [6:0]           cfg_addr,
  input  logic [NUM_PORTS:0]   cfg_wdata,
  input  logic                 cfg_flood_we,
  input  logic [1:0]           cfg_flood_sel,
  input  logic [5:0]           cfg_flood_idx
);
  localparam int MASK_W = NUM_PORTS + 1;
  localparam int DEPTH  = SRC_BASE + NUM_PORTS;

  logic [IDX_W-1:0]  dst_idx, aggr_idx, src_idx, rd_addr;
  logic              src_err;
  logic [MASK_W-1:0] rd_data;
  logic              tbl_we;

  // Table writes wait for an idle table (R7)
  assign tbl_we = cfg_tbl_we && !busy && (int'(cfg_addr) < DEPTH);

  pgm_index_gen #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .flood_we_i (cfg_flood_we),
    .flood_sel_i(cfg_flood_sel),
    .flood_idx_i(cfg_flood_idx),
    .hit_i      (req_hit),
    .dest_idx_i (req_dest_idx),
    .kind_i     (req_kind),
    .aggr_i     (req_aggr),
    .src_i      (req_src),
    .dst_idx_o  (dst_idx),
    .aggr_idx_o (aggr_idx),
    .src_idx_o  (src_idx),
    .src_err_o  (src_err)
  );

  pgm_table #(.DEPTH(DEPTH), .MASK_W(MASK_W)) u_tbl (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (tbl_we),
    .wr_addr_i      (cfg_addr),
    .wr_data_i      (cfg_wdata),
    .rd_addr_i      (rd_addr),
    .lookup_active_i(busy),
    .rd_data_o      (rd_data)
  );

  pgm_lookup_seq #(.MASK_W(MASK_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid),
    .dst_idx_i  (dst_idx),
    .aggr_idx_i (aggr_idx),
    .src_idx_i  (src_idx),
    .src_err_i  (src_err),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .busy_o     (busy),
    .res_valid_o(res_valid),
    .res_mask_o (res_mask),
    .res_err_o  (res_err)
  );

  assert_valid_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
endmodule

// File: tb/pgm_resolver_tb.sv
module pgm_resolver_tb;
  localparam int NP    = 8;
  localparam int PW    = 4;
  localparam int MW    = NP + 1;
  localparam int DEPTH = 80 + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_hit = 1'b0;
  logic [5:0]    req_dest_idx = '0;
  logic [1:0]    req_kind = '0;
  logic [3:0]    req_aggr = '0;
  logic [PW-1:0] req_src = '0;
  logic          busy, res_valid, res_err;
  logic [MW-1:0] res_mask;
  logic          cfg_tbl_we = 1'b0;
  logic [6:0]    cfg_addr = '0;
  logic [MW-1:0] cfg_wdata = '0;
  logic          cfg_flood_we = 1'b0;
  logic [1:0]    cfg_flood_sel = '0;
  logic [5:0]    cfg_flood_idx = '0;

  always #2.5 clk = ~clk;

  pgm_resolver #(.NUM_PORTS(NP), .PORT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_dest_idx(req_dest_idx), .req_kind(req_kind), .req_aggr(req_aggr),
    .req_src(req_src), .busy(busy), .res_valid(res_valid), .res_mask(res_mask),
    .res_err(res_err), .cfg_tbl_we(cfg_tbl_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_flood_we(cfg_flood_we),
    .cfg_flood_sel(cfg_flood_sel), .cfg_flood_idx(cfg_flood_idx)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference model
  logic [MW-1:0] tbl_m [DEPTH];
  int            fl_uc, fl_mc, fl_bc;
  int            m_phase, m_d, m_a, m_s;
  bit            m_errc, m_valid, m_err;
  logic [MW-1:0] m_mask;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_valid = 0; m_err = 0; m_mask = '0;
      fl_uc = 60; fl_mc = 61; fl_bc = 61;
      for (int i = 0; i < DEPTH; i++) tbl_m[i] = '0;
    end else begin
      m_valid = 0;
      if (m_phase == 3) begin
        m_valid = 1;
        m_err   = m_errc;
        m_mask  = m_errc ? '0 : (tbl_m[m_d] & tbl_m[m_a] & tbl_m[m_s]);
        m_phase = 0;
      end else if (m_phase != 0) begin
        m_phase++;
      end else begin
        if (cfg_tbl_we && int'(cfg_addr) < DEPTH) tbl_m[cfg_addr] = cfg_wdata;
        if (req_valid) begin
          if (req_hit)            m_d = int'(req_dest_idx);
          else if (req_kind == 0) m_d = fl_uc;
          else if (req_kind == 1) m_d = fl_mc;
          else                    m_d = fl_bc;
          m_a     = 64 + int'(req_aggr);
          m_errc  = (int'(req_src) >= NP);
          m_s     = m_errc ? 80 : 80 + int'(req_src);
          m_phase = 1;
        end
      end
      if (cfg_flood_we) begin
        case (cfg_flood_sel)
          2'd0: fl_uc = int'(cfg_flood_idx);
          2'd1: fl_mc = int'(cfg_flood_idx);
          2'd2: fl_bc = int'(cfg_flood_idx);
          default: ;
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_phase != 0), "R6 busy", int'(busy), int'(m_phase != 0));
      chk(res_valid == m_valid, "R6 valid", int'(res_valid), int'(m_valid));
      if (m_valid) begin
        chk(res_mask == m_mask, cur_tag, int'(res_mask), int'(m_mask));
        chk(res_err == m_err, "R8 err", int'(res_err), int'(m_err));
      end
    end
  end

  task automatic wr_tbl(input int addr, input logic [MW-1:0] data);
    @(negedge clk);
    cfg_tbl_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = data;
    while (busy) @(negedge clk);
    @(negedge clk);
    cfg_tbl_we = 1'b0;
  endtask

  task automatic wr_flood(input int sel, input int idx);
    @(negedge clk);
    cfg_flood_we = 1'b1; cfg_flood_sel = 2'(sel); cfg_flood_idx = 6'(idx);
    @(negedge clk);
    cfg_flood_we = 1'b0;
  endtask

  task automatic lookup(input bit hit, input int dst, input int kind,
                        input int aggr, input int src);
    @(negedge clk);
    req_valid = 1'b1; req_hit = hit; req_dest_idx = 6'(dst);
    req_kind = 2'(kind); req_aggr = 4'(aggr); req_src = PW'(src);
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [MW-1:0] init_val(input int i);
    if (i < NP)       return MW'(1) << i;
    if (i < 59)       return MW'((i * 37) ^ 9'h0A5);
    if (i == 59)      return 9'h100;
    if (i == 60)      return 9'h0FF;
    if (i == 61)      return 9'h1FF;
    if (i == 62)      return 9'h0F0;
    if (i == 63)      return 9'h00F;
    if (i < 80)       return 9'h1F0 | (MW'(1) << ((i - 64) & 3));
    return 9'h1FF & ~(MW'(1) << (i - 80));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    cur_tag = "R1";
    lookup(1, 5, 0, 0, 0); settle();
    // R1 default unicast flood index 60 after table load
    for (int i = 0; i < DEPTH; i++) wr_tbl(i, init_val(i));
    cur_tag = "R1";
    lookup(0, 0, 0, 0, 4); settle();
    // R2 hits
    cur_tag = "R2";
    for (int d = 0; d < 64; d += 7) begin
      lookup(1, d, 0, d & 15, d % NP); settle();
    end
    // R3 misses, all kinds
    cur_tag = "R3";
    for (int k = 0; k < 4; k++) begin
      lookup(0, 9, k, 5, 2); settle();
    end
    // R4 every aggregation code
    cur_tag = "R4";
    for (int a = 0; a < 16; a++) begin
      lookup(1, 61, 0, a, 7); settle();
    end
    // R5 every source port
    cur_tag = "R5";
    for (int s = 0; s < NP; s++) begin
      lookup(1, 60, 0, 3, s); settle();
    end
    // R8 out-of-range ingress port
    cur_tag = "R8";
    lookup(1, 61, 0, 0, NP); settle();
    lookup(1, 61, 0, 0, 15); settle();
    // R10 CPU bit passes through
    cur_tag = "R10";
    wr_tbl(64, 9'h1FF);
    wr_tbl(83, 9'h100);
    lookup(1, 59, 0, 0, 3); settle();
    // R9 flood writes, including the ignored select value 3
    cur_tag = "R9";
    wr_flood(0, 62);
    wr_flood(1, 63);
    wr_flood(2, 59);
    wr_flood(3, 1);
    for (int k = 0; k < 4; k++) begin
      lookup(0, 0, k, 0, 1); settle();
    end
    // R9 flood write in the same cycle as acceptance: old value used
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_kind = 2'd0; req_aggr = 4'd1; req_src = PW'(2);
    cfg_flood_we = 1'b1; cfg_flood_sel = 2'd0; cfg_flood_idx = 6'd61;
    @(negedge clk);
    req_valid = 1'b0; cfg_flood_we = 1'b0;
    settle();
    // R7 table write during a lookup is held until idle
    cur_tag = "R7";
    lookup(1, 20, 0, 2, 2);
    wr_tbl(20, 9'h000);
    settle();
    lookup(1, 20, 0, 2, 2); settle();
    // R6 requests held high back to back; extra cycles ignored
    cur_tag = "R6";
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b1; req_dest_idx = 6'd3; req_aggr = 4'd3; req_src = PW'(5);
    repeat (13) @(negedge clk);
    req_valid = 1'b0;
    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule